// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two buses, called A and B, in either direction, without inverting it. The data width is split into independent byte lanes. Each lane holds two storage registers. The A-side register samples the A bus on its own capture clock, and the B-side register samples the B bus on a second capture clock. When a lane drives a bus, a per-lane select decides what goes out. It can pass the opposite bus through live, as a purely combinational path. It can also present the value held in the opposite bus's register.

Each bus is exposed as three port groups: an input vector, an output vector and one output-enable per lane. An outer wrapper can merge these into true bidirectional nets. Each lane has an isolate control that releases both buses, so both act as inputs. When the lane is not isolated, a direction control picks which bus it drives. The registers keep capturing on every rising capture edge, whatever the isolate and direction settings are. Tying the controls of all lanes together gives one full-width transceiver.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Lane k occupies bits [8k+7:8k] of every bus vector and bit k of every control and enable vector. Its outputs depend only on lane k's controls, capture clocks and data bits.
- R2: A rising edge of `a_cap_clk[k]` loads lane k's A register from that lane's `a_in` bits, and a rising edge of `b_cap_clk[k]` loads the B register from `b_in`. A falling edge loads nothing.
- R3: Capture happens regardless of `isolate` and `drive_b`, including while both enables of the lane are low.
- R4: With `isolate[k]`=1, both `a_oe[k]` and `b_oe[k]` are 0, and the lane's `a_out` and `b_out` bits are all 0.
- R5: With `isolate[k]`=0, `drive_b[k]`=1 sets `b_oe[k]`=1 and `a_oe[k]`=0 with the lane's `a_out` bits 0. `drive_b[k]`=0 sets `a_oe[k]`=1 and `b_oe[k]`=0 with the lane's `b_out` bits 0. The two enables of a lane are never both 1.
- R6: While B is driven and `b_src_reg[k]`=0, the lane's `b_out` equals its `a_in` bits unchanged, with no clock involved.
- R7: While B is driven and `b_src_reg[k]`=1, the lane's `b_out` equals the A register.
- R8: While A is driven and `a_src_reg[k]`=0, the lane's `a_out` equals its `b_in` bits unchanged, with no clock involved.
- R9: While A is driven and `a_src_reg[k]`=1, the lane's `a_out` equals the B register.
- R10: A capture edge that occurs in stored mode on the driven bus shows the newly captured value on that bus's output right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | Value seen on the A bus |
| b_in | input | 16 | Value seen on the B bus |
| isolate | input | 2 | Per lane: 1 releases both buses |
| drive_b | input | 2 | Per lane: 1 drives B, 0 drives A (when not isolated) |
| a_cap_clk | input | 2 | Per lane: rising edge loads the A register from a_in |
| b_cap_clk | input | 2 | Per lane: rising edge loads the B register from b_in |
| b_src_reg | input | 2 | Per lane: 1 drives B from the A register, 0 passes a_in live |
| a_src_reg | input | 2 | Per lane: 1 drives A from the B register, 0 passes b_in live |
| a_out | output | 16 | Value driven onto the A bus |
| a_oe | output | 2 | Per lane: A bus output enable |
| b_out | output | 16 | Value driven onto the B bus |
| b_oe | output | 2 | Per lane: B bus output enable |

## Verification
The hardest case to reach is a capture edge that lands while the same lane drives the opposite bus in stored mode. The output must then switch to the freshly captured value within the same step, and the neighbouring lane must keep its older register contents. The registers have no reset, so the stimulus first loads both registers while the lanes are isolated. It then pulses one lane's capture clock with new data while stored mode is selected, and expects the new value on one lane and the old value on the other. A walk through all sixteen control combinations of each lane holds the other lane fixed in stored mode, which shows that the lanes do not interact.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_ISO   = 2'b00,
    MODE_DRV_A = 2'b01,
    MODE_DRV_B = 2'b10
  } lane_mode_e;

  function automatic lane_mode_e decode_mode(input logic iso, input logic drv_b);
    if (iso)        return MODE_ISO;
    else if (drv_b) return MODE_DRV_B;
    else            return MODE_DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_lane_ctrl.sv
module xcvr_lane_ctrl
  import xcvr_pkg::*;
(
  input  logic iso,
  input  logic drv_b,
  output logic a_oe,
  output logic b_oe
);
  lane_mode_e mode;

  always_comb begin
    mode = decode_mode(iso, drv_b);
    a_oe = 1'b0;
    b_oe = 1'b0;
    case (mode)
      MODE_DRV_A: a_oe = 1'b1;
      MODE_DRV_B: b_oe = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         cap_clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge cap_clk) begin
    q <= d;
  end
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         use_reg,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  logic [W-1:0] pick;

  always_comb begin
    pick = use_reg ? stored : live;
    y    = en ? pick : '0;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         iso,
  input  logic         drv_b,
  input  logic         a_clk,
  input  logic         b_clk,
  input  logic         b_sel_reg,
  input  logic         a_sel_reg,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] q_a;
  logic [W-1:0] q_b;

  xcvr_lane_ctrl u_ctrl (
    .iso  (iso),
    .drv_b(drv_b),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  xcvr_cap_reg #(.W(W)) u_reg_a (.cap_clk(a_clk), .d(a_in), .q(q_a));
  xcvr_cap_reg #(.W(W)) u_reg_b (.cap_clk(b_clk), .d(b_in), .q(q_b));

  xcvr_out_mux #(.W(W)) u_mux_b (
    .en(b_oe), .use_reg(b_sel_reg), .live(a_in), .stored(q_a), .y(b_out)
  );
  xcvr_out_mux #(.W(W)) u_mux_a (
    .en(a_oe), .use_reg(a_sel_reg), .live(b_in), .stored(q_b), .y(a_out)
  );

  // Checks sampled at capture edges, where every input has settled.
  always @(posedge a_clk or posedge b_clk) begin
    assert_oe_excl_R5: assert (!(a_oe && b_oe))
      else $error("both enables of a lane high");
    assert_iso_R4: assert (!iso || (!a_oe && !b_oe && a_out == '0 && b_out == '0))
      else $error("isolated lane drives a bus");
    assert_live_b_R6: assert (!(b_oe && !b_sel_reg) || b_out == a_in)
      else $error("live path to B differs from A input");
    assert_reg_b_R7: assert (!(b_oe && b_sel_reg) || b_out == q_a)
      else $error("stored path to B differs from A register");
    assert_live_a_R8: assert (!(a_oe && !a_sel_reg) || a_out == b_in)
      else $error("live path to A differs from B input");
    assert_reg_a_R9: assert (!(a_oe && a_sel_reg) || a_out == q_b)
      else $error("stored path to A differs from B register");
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic [LANES-1:0] isolate,
  input  logic [LANES-1:0] drive_b,
  input  logic [LANES-1:0] a_cap_clk,
  input  logic [LANES-1:0] b_cap_clk,
  input  logic [LANES-1:0] b_src_reg,
  input  logic [LANES-1:0] a_src_reg,
  output logic [BUS_W-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  output logic [BUS_W-1:0] b_out,
  output logic [LANES-1:0] b_oe
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    xcvr_lane #(.W(LANE_W)) u_lane (
      .a_in     (a_in[k*LANE_W +: LANE_W]),
      .b_in     (b_in[k*LANE_W +: LANE_W]),
      .iso      (isolate[k]),
      .drv_b    (drive_b[k]),
      .a_clk    (a_cap_clk[k]),
      .b_clk    (b_cap_clk[k]),
      .b_sel_reg(b_src_reg[k]),
      .a_sel_reg(a_src_reg[k]),
      .a_out    (a_out[k*LANE_W +: LANE_W]),
      .a_oe     (a_oe[k]),
      .b_out    (b_out[k*LANE_W +: LANE_W]),
      .b_oe     (b_oe[k])
    );
  end
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  logic        clk = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [1:0]  isolate = 2'b11, drive_b = '0, a_cap_clk = '0, b_cap_clk = '0;
  logic [1:0]  b_src_reg = '0, a_src_reg = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [35:0] expq[$];
  string       tagq[$];
  logic [7:0]  ra [2];
  logic [7:0]  rb [2];

  always #5 clk = ~clk;

  bus_xcvr_reg u0 (
    .a_in(a_in), .b_in(b_in), .isolate(isolate), .drive_b(drive_b),
    .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk),
    .b_src_reg(b_src_reg), .a_src_reg(a_src_reg),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // Driver: applies one stimulus, updates the register model, queues the expectation.
  task automatic step(input logic [1:0] iso, input logic [1:0] dvb,
                      input logic [1:0] bsr, input logic [1:0] asr,
                      input logic [15:0] a, input logic [15:0] b,
                      input logic [1:0] pa, input logic [1:0] pb,
                      input string tag);
    logic [15:0] ea, eb;
    logic [1:0]  eoa, eob;
    @(posedge clk);
    #1;
    a_cap_clk = '0; b_cap_clk = '0;
    isolate = iso; drive_b = dvb; b_src_reg = bsr; a_src_reg = asr;
    a_in = a; b_in = b;
    #1;
    a_cap_clk = pa; b_cap_clk = pb;
    for (int k = 0; k < 2; k++) begin
      if (pa[k]) ra[k] = a[k*8 +: 8];
      if (pb[k]) rb[k] = b[k*8 +: 8];
    end
    ea = '0; eb = '0; eoa = '0; eob = '0;
    for (int k = 0; k < 2; k++) begin
      if (!iso[k]) begin
        if (dvb[k]) begin
          eob[k] = 1'b1;
          eb[k*8 +: 8] = bsr[k] ? ra[k] : a[k*8 +: 8];
        end else begin
          eoa[k] = 1'b1;
          ea[k*8 +: 8] = asr[k] ? rb[k] : b[k*8 +: 8];
        end
      end
    end
    expq.push_back({ea, eb, eoa, eob});
    tagq.push_back(tag);
  endtask

  // Monitor: compares away from the edges.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [35:0] e, act;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      act = {a_out, b_out, a_oe, b_oe};
      tests++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(2'b11, 2'b00, 2'b00, 2'b00, 16'h0000, 16'h0000, 2'b00, 2'b00, "R4 initial isolation");
    step(2'b11, 2'b10, 2'b11, 2'b11, 16'h3C81, 16'h5AE7, 2'b00, 2'b00, "R4 isolation with selects");
    step(2'b11, 2'b01, 2'b00, 2'b00, 16'h12A4, 16'h9B6D, 2'b11, 2'b11, "R3 capture while isolated");
    step(2'b00, 2'b11, 2'b11, 2'b00, 16'hFFFF, 16'h0000, 2'b00, 2'b00, "R3 R7 stored A to B");
    step(2'b00, 2'b00, 2'b00, 2'b11, 16'h0000, 16'hFFFF, 2'b00, 2'b00, "R3 R9 stored B to A");
    step(2'b00, 2'b11, 2'b00, 2'b00, 16'h00FF, 16'hAAAA, 2'b00, 2'b00, "R6 live A to B");
    step(2'b00, 2'b11, 2'b00, 2'b11, 16'hC35A, 16'h1111, 2'b00, 2'b00, "R6 R5 live A to B");
    step(2'b00, 2'b11, 2'b00, 2'b00, 16'h8001, 16'h7FFE, 2'b00, 2'b00, "R6 live A to B edges");
    step(2'b00, 2'b00, 2'b00, 2'b00, 16'h5555, 16'hF00F, 2'b00, 2'b00, "R8 live B to A");
    step(2'b00, 2'b00, 2'b11, 2'b00, 16'h2222, 16'h0E71, 2'b00, 2'b00, "R8 R5 live B to A");
    step(2'b00, 2'b11, 2'b11, 2'b00, 16'h4D6B, 16'h0000, 2'b01, 2'b00, "R10 R1 capture in stored mode lane0");
    step(2'b00, 2'b11, 2'b11, 2'b00, 16'h99EE, 16'h0000, 2'b00, 2'b00, "R2 falling edge keeps A register");
    step(2'b00, 2'b00, 2'b00, 2'b11, 16'h0000, 16'h7C3E, 2'b00, 2'b10, "R10 R1 capture in stored mode lane1");
    step(2'b00, 2'b00, 2'b00, 2'b11, 16'h0000, 16'h1248, 2'b00, 2'b00, "R2 falling edge keeps B register");
    step(2'b00, 2'b01, 2'b01, 2'b10, 16'hB1C2, 16'hD3E4, 2'b11, 2'b11, "R10 R2 mixed directions");
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic [1:0] iso, dvb, bsr, asr;
        iso = 2'b00; dvb = 2'b11; bsr = 2'b11; asr = 2'b00;
        iso[k] = c[0]; dvb[k] = c[1]; bsr[k] = c[2]; asr[k] = c[3];
        step(iso, dvb, bsr, asr, 16'h1111 * c[15:0] ^ 16'hA5C3,
             16'h0F0F ^ (16'h0101 * c[15:0]), 2'b00, 2'b00, "R1 R5 control walk");
      end
    end
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule